// File: doc/BRIEF.md
# Shift-Register Chain XOR Random Word Generator

The block produces a stream of uniformly distributed pseudo-random words of `R` bits. Its state is not a single wide register. It is `R` shift-register FIFOs of unequal lengths whose lengths add up to `N` state bits. On every step each FIFO shifts by one place. Its head takes the XOR of `T` FIFO tail bits, which is a function that fits a single small lookup table. The output word is a fixed reordering of the `R` FIFO tails, so neighbouring output bits do not show the plain dependency of neighbouring FIFOs.

Compile-time functions in a package derive all connectivity from a configuration seed `CFG_SEED`:

- **FIFO lengths.** Every FIFO starts at length 1. The functions then add one stage at a time to a pseudo-randomly chosen FIFO until the total reaches `N`.
- **Tap 0.** FIFO `i` takes the tail of FIFO `(i+1) mod R`. This closes all FIFOs into one loop.
- **Taps 1 to `T-1`.** Each comes from its own permutation of the tails.
- **Output order.** A further permutation sets the order of the output bits.

Searching for a seed that gives the full period of 2^N − 1 is done elsewhere.

A 64-bit seed expands into the whole state over `BEATS = ceil(N/64)` load cycles. An all-zero seed is replaced by a fixed non-zero constant, because the all-zero state would lock the feedback. The controller has three states:

- **`ST_IDLE`.** Entered on reset. Unseeded, and enable is ignored.
- **`ST_LOAD`.** The seed is being shifted in. Entered from `ST_IDLE` or `ST_RUN` on `seed_valid`.
- **`ST_RUN`.** The block is generating. It goes back to `ST_LOAD` on `seed_valid`.

The transition from `ST_LOAD` to `ST_RUN` is taken after the last beat.

Top module: `srchain_rng`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `out_valid` is 0 and `out_word` is 0. After reset the generator stays unseeded: `enable` produces no output until a seed has been loaded.
- R2: A `seed_valid` pulse in the idle or running state starts a load that lasts exactly `BEATS` cycles. During the load, `out_valid` stays 0, `enable` has no effect, and a further `seed_valid` is ignored.
- R3: Load beat k (k = 0 up to `BEATS-1`) first shifts the N-bit state up by 64 bits and then writes the effective seed, rotated left by k, into state bits [63:0]. FIFO 0 occupies the lowest state bits, followed by FIFO 1, and so on. Within a FIFO, the tail is its lowest bit and the head is its highest bit.
- R4: A seed of all zeros is replaced by the constant `ZERO_SUB` (default 64'h9E3779B97F4A7C15). The loaded state and the output stream are then identical to those produced by seeding with `ZERO_SUB`.
- R5: In the running state, a cycle with `enable` high and `seed_valid` low is a step. On the next cycle `out_valid` is 1 and `out_word[j]` equals the tail of FIFO `out_sel(j)` as it was before the step.
- R6: In a non-step cycle, `out_valid` is 0 on the next cycle, and both `out_word` and every FIFO keep their contents. The stream resumes as if no pause had occurred.
- R7: On a step, every FIFO shifts one place toward its tail. Its head takes the XOR of the `T` tails selected by `tap_src`. Tap 0 of FIFO i is FIFO (i+1) mod R, so the tap-0 links form one loop through all R FIFOs.
- R8: Over all R FIFOs and all T taps, every FIFO tail is selected exactly T times. `out_sel` is a permutation of 0 to R-1.
- R9: Every FIFO has a length of at least 1, and the lengths sum to N.
- R10: Once loading has finished, the state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_valid | input | 1 | Starts a seed load |
| seed | input | 64 | Seed value sampled with `seed_valid` |
| enable | input | 1 | Requests one step per cycle while running |
| out_word | output | R | Permuted FIFO tails from the last step |
| out_valid | output | 1 | `out_word` was updated on the previous edge |

## Verification
The bench compares every word against a model built on the package's connection tables. A wrong tap, a wrong FIFO length or an off-by-one in the shift would therefore diverge within a few dozen words.

It loads a zero seed and then the substitute constant, and checks that the two streams match. A design that let zero through would emit all zeros.

Three boundary cases are targeted:
- Enable is held high during a load. A design that stepped during the load would come out shifted by some words.
- A second seed pulse is given in the middle of a load. A design that restarted would show the second seed's stream.
- A reseed pulse is coincident with enable. A design that stepped on that cycle would raise valid.

Random enable gaps check that pauses neither drop nor repeat words.

// File: rtl/srchain_pkg.sv
package srchain_pkg;

    typedef int unsigned u32_t;

    localparam int MAX_R  = 256;
    localparam int SEED_W = 64;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_e;

    function automatic u32_t lcg(u32_t x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    // Length (want_base = 0) or lowest state bit (want_base = 1) of one FIFO.
    function automatic int fifo_geom(int r, int n, u32_t seed, int idx, bit want_base);
        int   len [MAX_R];
        u32_t x;
        int   acc;
        x = seed ^ 32'hA5A5_0001;
        for (int i = 0; i < MAX_R; i++) len[i] = 1;
        for (int s = 0; s < n - r; s++) begin
            x = lcg(x);
            len[int'((x >> 8) % u32_t'(r))] += 1;
        end
        if (!want_base) return len[idx];
        acc = 0;
        for (int i = 0; i < idx; i++) acc += len[i];
        return acc;
    endfunction

    // Element idx of a seeded shuffle of 0..r-1.
    function automatic int perm_at(int r, u32_t seed, int idx);
        int   p [MAX_R];
        u32_t x;
        int   j;
        int   tmp;
        x = seed;
        for (int i = 0; i < MAX_R; i++) p[i] = i;
        for (int i = r - 1; i > 0; i--) begin
            x = lcg(x);
            j = int'((x >> 8) % u32_t'(i + 1));
            tmp = p[i];
            p[i] = p[j];
            p[j] = tmp;
        end
        return p[idx];
    endfunction

    // Round 0 closes the single loop; later rounds are permutations.
    function automatic int tap_src(int r, u32_t seed, int fifo, int round);
        if (round == 0) return (fifo + 1) % r;
        return perm_at(r, seed ^ (u32_t'(round) * 32'h9E37_79B9), fifo);
    endfunction

    function automatic int out_sel(int r, u32_t seed, int bit_idx);
        return perm_at(r, seed ^ 32'h5BD1_E995, bit_idx);
    endfunction

endpackage

// File: rtl/srchain_ctrl.sv
module srchain_ctrl
    import srchain_pkg::*;
#(
    parameter int   BEATS    = 16,
    parameter logic [63:0] ZERO_SUB = 64'h9E37_79B9_7F4A_7C15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        seed_valid,
    input  logic [63:0] seed,
    input  logic        enable,
    output logic        load_en,
    output logic [63:0] load_word,
    output logic        step_en,
    output logic        running
);

    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    gen_state_e       st, st_nxt;
    logic [CNT_W-1:0] beat;
    logic [63:0]      rot;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (seed_valid) st_nxt = ST_LOAD;
            ST_LOAD: if (beat == CNT_W'(BEATS - 1)) st_nxt = ST_RUN;
            ST_RUN:  if (seed_valid) st_nxt = ST_LOAD;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
            rot  <= '0;
        end else if (st != ST_LOAD && seed_valid) begin
            beat <= '0;
            rot  <= (seed == '0) ? ZERO_SUB : seed;
        end else if (st == ST_LOAD) begin
            beat <= beat + 1'b1;
            rot  <= {rot[62:0], rot[63]};
        end
    end

    always_comb begin
        load_en   = (st == ST_LOAD);
        load_word = rot;
        running   = (st == ST_RUN);
        step_en   = running && enable && !seed_valid;
    end

    assert_load_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        load_en |-> load_word != '0);

    assert_load_ends_in_run_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(load_en) |-> running);

endmodule

// File: rtl/srchain_store.sv
module srchain_store
    import srchain_pkg::*;
#(
    parameter int   R        = 32,
    parameter int   T        = 4,
    parameter int   N        = 1024,
    parameter u32_t CFG_SEED = 32'h1234_5678
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [SEED_W-1:0] load_word,
    input  logic              step_en,
    input  logic              running,
    output logic [R-1:0]      tails
);

    logic [N-1:0] state;
    logic [N-1:0] shifted;
    logic [R-1:0] fb;

    for (genvar i = 0; i < R; i++) begin : g_fifo
        localparam int BASE = fifo_geom(R, N, CFG_SEED, i, 1'b1);
        localparam int LEN  = fifo_geom(R, N, CFG_SEED, i, 1'b0);
        logic [T-1:0] taps;

        for (genvar k = 0; k < T; k++) begin : g_tap
            localparam int SRC = tap_src(R, CFG_SEED, i, k);
            assign taps[k] = tails[SRC];
        end

        assign tails[i] = state[BASE];
        assign fb[i]    = ^taps;

        if (LEN == 1) begin : g_single
            assign shifted[BASE] = fb[i];
        end else begin : g_chain
            assign shifted[BASE+LEN-1]    = fb[i];
            assign shifted[BASE+LEN-2:BASE] = state[BASE+LEN-1:BASE+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          state <= '0;
        else if (load_en) state <= {state[N-SEED_W-1:0], load_word};
        else if (step_en) state <= shifted;
    end

    assert_state_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
        running |-> |state);

    assert_state_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (running && !load_en && !step_en) |=> $stable(state));

endmodule

// File: rtl/srchain_outmap.sv
module srchain_outmap
    import srchain_pkg::*;
#(
    parameter int   R        = 32,
    parameter u32_t CFG_SEED = 32'h1234_5678
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  logic [R-1:0] tails,
    output logic [R-1:0] out_word,
    output logic         out_valid
);

    logic [R-1:0] mixed;

    for (genvar j = 0; j < R; j++) begin : g_bit
        localparam int SEL = out_sel(R, CFG_SEED, j);
        assign mixed[j] = tails[SEL];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= step_en;
            if (step_en) out_word <= mixed;
        end
    end

    assert_word_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(out_word));

endmodule

// File: rtl/srchain_rng.sv
module srchain_rng
    import srchain_pkg::*;
#(
    parameter int   R        = 32,
    parameter int   T        = 4,
    parameter int   N        = 1024,
    parameter u32_t CFG_SEED = 32'h1234_5678,
    parameter logic [63:0] ZERO_SUB = 64'h9E37_79B9_7F4A_7C15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seed_valid,
    input  logic [63:0]  seed,
    input  logic         enable,
    output logic [R-1:0] out_word,
    output logic         out_valid
);

    localparam int BEATS = (N + SEED_W - 1) / SEED_W;

    logic              load_en;
    logic [SEED_W-1:0] load_word;
    logic              step_en;
    logic              running;
    logic [R-1:0]      tails;

    srchain_ctrl #(.BEATS(BEATS), .ZERO_SUB(ZERO_SUB)) u_ctrl (
        .clk(clk), .rst(rst), .seed_valid(seed_valid), .seed(seed),
        .enable(enable), .load_en(load_en), .load_word(load_word),
        .step_en(step_en), .running(running)
    );

    srchain_store #(.R(R), .T(T), .N(N), .CFG_SEED(CFG_SEED)) u_store (
        .clk(clk), .rst(rst), .load_en(load_en), .load_word(load_word),
        .step_en(step_en), .running(running), .tails(tails)
    );

    srchain_outmap #(.R(R), .CFG_SEED(CFG_SEED)) u_outmap (
        .clk(clk), .rst(rst), .step_en(step_en), .tails(tails),
        .out_word(out_word), .out_valid(out_valid)
    );

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_word == '0));

endmodule

// File: tb/sim_srchain_rng.sv
module sim_srchain_rng;
    import srchain_pkg::*;

    localparam int   R          = 32;
    localparam int   T          = 4;
    localparam int   N          = 1024;
    localparam u32_t CFG        = 32'h1234_5678;
    localparam logic [63:0] SUB = 64'h9E37_79B9_7F4A_7C15;
    localparam int   BEATS      = (N + 63) / 64;
    localparam int   CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         seed_valid = 1'b0;
    logic [63:0]  seed = '0;
    logic         enable = 1'b0;
    logic [R-1:0] out_word;
    logic         out_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int len_t  [R];
    int base_t [R];
    int tap_t  [R][T];
    int sel_t  [R];

    bit   [N-1:0] mv;
    logic [R-1:0] last_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    srchain_rng #(.R(R), .T(T), .N(N), .CFG_SEED(CFG), .ZERO_SUB(SUB)) u0 (
        .clk(clk), .rst(rst), .seed_valid(seed_valid), .seed(seed),
        .enable(enable), .out_word(out_word), .out_valid(out_valid)
    );

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic void model_load(logic [63:0] s);
        logic [63:0] rot;
        rot = (s == '0) ? SUB : s;
        for (int k = 0; k < BEATS; k++) begin
            mv  = {mv[N-65:0], rot};
            rot = {rot[62:0], rot[63]};
        end
    endfunction

    function automatic logic [R-1:0] model_step();
        logic [R-1:0] t;
        logic [R-1:0] w;
        logic [R-1:0] f;
        for (int i = 0; i < R; i++) t[i] = mv[base_t[i]];
        for (int j = 0; j < R; j++) w[j] = t[sel_t[j]];
        for (int i = 0; i < R; i++) begin
            f[i] = 1'b0;
            for (int k = 0; k < T; k++) f[i] ^= t[tap_t[i][k]];
        end
        for (int i = 0; i < R; i++) begin
            for (int b = 0; b < len_t[i] - 1; b++)
                mv[base_t[i] + b] = mv[base_t[i] + b + 1];
            mv[base_t[i] + len_t[i] - 1] = f[i];
        end
        return w;
    endfunction

    // Seed pulse, then the load window; a stray pulse may be injected mid-load.
    task automatic do_seed(logic [63:0] s, bit en_load, bit stray);
        seed_valid = 1'b1;
        seed       = s;
        enable     = en_load;
        tick();
        check(out_valid == 1'b0, "R2 no step on seed cycle", 64'(out_valid), 64'd0);
        seed_valid = 1'b0;
        for (int b = 0; b < BEATS; b++) begin
            if (stray && b == BEATS / 2) begin
                seed_valid = 1'b1;
                seed       = ~s;
            end else begin
                seed_valid = 1'b0;
            end
            tick();
            check(out_valid == 1'b0, "R2 valid low in load", 64'(out_valid), 64'd0);
        end
        seed_valid = 1'b0;
        enable     = 1'b0;
        model_load(s);
        last_word = out_word;
    endtask

    task automatic run_steps(int count, int pct);
        logic [R-1:0] exp;
        for (int n = 0; n < count; n++) begin
            bit en;
            en = ($urandom % 100) < pct;
            enable = en;
            tick();
            check(out_valid == en, "R5/R6 valid follows step", 64'(out_valid), 64'(en));
            if (en) begin
                exp = model_step();
                check(out_word === exp, "R5 R7 word matches model", 64'(out_word), 64'(exp));
            end else begin
                check(out_word === last_word, "R6 word held in pause", 64'(out_word), 64'(last_word));
            end
            last_word = out_word;
        end
        enable = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [R-1:0] zero_words [8];
        int sum;
        int use_cnt [R];
        int cur;
        bit perm_ok;
        bit seen [R];

        void'($urandom(32'd20240611));

        for (int i = 0; i < R; i++) begin
            len_t[i]  = fifo_geom(R, N, CFG, i, 1'b0);
            base_t[i] = fifo_geom(R, N, CFG, i, 1'b1);
            sel_t[i]  = out_sel(R, CFG, i);
            for (int k = 0; k < T; k++) tap_t[i][k] = tap_src(R, CFG, i, k);
        end

        // R9: lengths
        sum = 0;
        for (int i = 0; i < R; i++) begin
            sum += len_t[i];
            check(len_t[i] >= 1, "R9 fifo length at least 1", 64'(len_t[i]), 64'd1);
        end
        check(sum == N, "R9 lengths sum to N", 64'(sum), 64'(N));

        // R8: tap usage and output permutation
        for (int i = 0; i < R; i++) begin
            use_cnt[i] = 0;
            seen[i] = 1'b0;
        end
        for (int i = 0; i < R; i++)
            for (int k = 0; k < T; k++) use_cnt[tap_t[i][k]]++;
        for (int i = 0; i < R; i++)
            check(use_cnt[i] == T, "R8 tail used T times", 64'(use_cnt[i]), 64'(T));
        perm_ok = 1'b1;
        for (int j = 0; j < R; j++) begin
            if (seen[sel_t[j]]) perm_ok = 1'b0;
            seen[sel_t[j]] = 1'b1;
        end
        check(perm_ok, "R8 output order is a permutation", 64'(perm_ok), 64'd1);

        // R7: tap 0 links form one loop of length R
        cur = 0;
        for (int s = 1; s < R; s++) begin
            cur = tap_t[cur][0];
            check(cur != 0, "R7 loop closes early", 64'(cur), 64'd1);
        end
        cur = tap_t[cur][0];
        check(cur == 0, "R7 loop closes after R links", 64'(cur), 64'd0);

        // R1: reset state, enable ignored in reset
        enable = 1'b1;
        repeat (3) tick();
        check(out_valid == 1'b0, "R1 valid low in reset", 64'(out_valid), 64'd0);
        check(out_word == '0, "R1 word zero in reset", 64'(out_word), 64'd0);
        rst = 1'b0;
        repeat (5) tick();
        check(out_valid == 1'b0, "R1 unseeded enable ignored", 64'(out_valid), 64'd0);

        // R2 R3: seed with enable held through the load
        do_seed(64'h0123_4567_89AB_CDEF, 1'b1, 1'b0);
        run_steps(300, 100);
        run_steps(600, 50);

        // R2: reseed while running, enable high on the pulse, stray pulse mid-load
        enable = 1'b1;
        do_seed({$urandom, $urandom}, 1'b1, 1'b1);
        run_steps(400, 70);

        // R3 corner: single-bit seed
        do_seed(64'h1, 1'b0, 1'b0);
        run_steps(300, 90);

        // R4: zero seed against the substitute constant
        do_seed(64'h0, 1'b0, 1'b0);
        enable = 1'b1;
        for (int n = 0; n < 8; n++) begin
            logic [R-1:0] exp;
            tick();
            exp = model_step();
            zero_words[n] = out_word;
            check(out_word === exp, "R4 zero seed stream", 64'(out_word), 64'(exp));
            check(out_word != '0 || n > 0, "R4 zero seed not stuck", 64'(out_word), 64'd1);
        end
        enable = 1'b0;
        do_seed(SUB, 1'b0, 1'b0);
        enable = 1'b1;
        for (int n = 0; n < 8; n++) begin
            logic [R-1:0] exp;
            tick();
            exp = model_step();
            check(out_word === zero_words[n], "R4 zero equals substitute", 64'(out_word), 64'(zero_words[n]));
        end
        enable = 1'b0;
        tick();
        last_word = out_word;
        run_steps(200, 40);

        // R1: reset while running, then unseeded again
        enable = 1'b1;
        rst = 1'b1;
        tick();
        check(out_valid == 1'b0, "R1 valid cleared by reset", 64'(out_valid), 64'd0);
        check(out_word == '0, "R1 word cleared by reset", 64'(out_word), 64'd0);
        rst = 1'b0;
        repeat (4) tick();
        check(out_valid == 1'b0, "R1 idle after reset ignores enable", 64'(out_valid), 64'd0);
        enable = 1'b0;

        // R10 through a fresh random seed and long run
        do_seed({$urandom, $urandom}, 1'b0, 1'b0);
        run_steps(1500, 60);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule